// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog timer with two timeout phases that run one after the other. Software reaches it through three 32-bit registers on a word-addressed bus. Writes take effect at a clock edge. Reads are combinational on the address. A prescaler divides the clock into ticks. A 5-bit tick count sets the length of each phase. When the first phase ends, the block raises a pre-timeout interrupt. When the second phase ends, it pulses one of three reset outputs, chosen by a mode field.

Software keeps the system alive by writing the kick bit while the first phase is still running. Once the first phase has expired, the watchdog is committed. Neither a kick nor clearing the enable bit can stop it, and the selected reset follows when the second phase ends.

The tick length is 2^(BASE_LOG2 + PS) clock cycles, where PS is the 2-bit scale field. BASE_LOG2 defaults to 25. A smaller value shortens the tick for simulation.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset, the control register reads 0x0000_0001. This means the CPU reset mode is selected and enable is clear. The status register and the kick register read 0, and the interrupt and all three reset outputs are low.
- R2: Writing the control register (byte offset 0x8) with bit 31 set starts phase one. Let L = 2^(BASE_LOG2+PS), where PS is control bits 30:29. The interrupt output rises exactly L*(F1+1) cycles after the enabling write edge, where F1 is control bits 26:22. At the same time status bit 31 (byte offset 0x4) is set.
- R3: Phase two then lasts L*(F2+1) cycles, where F2 is control bits 19:15. At the end of phase two the reset pulse is issued, and in the same cycle status bit 30 is set.
- R4: Control bits 1:0 select the reset output. A value of 0 drives the chip reset, 1 the CPU reset and 2 the software reset. A value of 3 drives no reset output, although status bit 30 is still set.
- R5: The reset output is high for exactly one cycle. After the pulse, the block is idle and the enable bit reads 0.
- R6: Status bits are write-one-to-clear. If a clear and a set of the same bit fall in the same cycle, the set wins. The interrupt output equals status bit 31.
- R7: The control register reads back the enable state and the fields at bits 30:29, 26:22, 19:15 and 1:0. All other control bits read 0. The kick register (byte offset 0x0) always reads 0.
- R8: During phase one, a write to offset 0x0 with bit 31 set clears the prescaler and the tick count, so phase one restarts in full. This also holds when the kick falls in the very cycle in which phase one would expire; the interrupt is then not raised.
- R9: A kick written during phase two has no effect, and the reset arrives on its original schedule.
- R10: During phase two, a control write that clears enable is ignored. The enable bit keeps reading 1 and the reset still arrives on schedule.
- R11: Clearing enable during phase one stops the count and raises neither the interrupt nor a reset. Enabling again starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_pre_o | output | 1 | Pre-timeout interrupt, level of status bit 31 |
| rst_chip_o | output | 1 | Whole-chip reset pulse |
| rst_cpu_o | output | 1 | CPU-only reset pulse |
| rst_soft_o | output | 1 | Software reset pulse |

## Verification
Two pairs of events can fall in the same cycle. A kick can land on the exact edge at which phase one expires, and a write-one-to-clear of status bit 31 can land on the edge that sets that bit. The bench counts the edges from the enabling write and places each of these writes on the computed expiry edge. It then checks two outcomes: a simultaneous kick suppresses the interrupt and restarts the full phase, and a simultaneous clear leaves the bit set. A second clear one edge later must then take effect.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned REG_ADDR_W = 4;
    localparam int unsigned SCALE_W    = 2;
    localparam int unsigned PHASE_W    = 5;
    localparam int unsigned MODE_W     = 2;
    localparam int unsigned NUM_TGT    = 3;

    localparam logic [REG_ADDR_W-1:0] OFS_KICK = 4'h0;
    localparam logic [REG_ADDR_W-1:0] OFS_STAT = 4'h4;
    localparam logic [REG_ADDR_W-1:0] OFS_CTRL = 4'h8;

    localparam int unsigned KICK_BIT    = 31;
    localparam int unsigned STAT_F1_BIT = 31;
    localparam int unsigned STAT_F2_BIT = 30;
    localparam int unsigned CTL_EN_BIT  = 31;
    localparam int unsigned CTL_PS_LSB  = 29;
    localparam int unsigned CTL_F1_LSB  = 22;
    localparam int unsigned CTL_F2_LSB  = 15;
    localparam int unsigned CTL_MD_LSB  = 0;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef enum logic [MODE_W-1:0] {
        RM_CHIP = 2'd0,
        RM_CPU  = 2'd1,
        RM_SOFT = 2'd2,
        RM_NONE = 2'd3
    } rmode_e;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [PHASE_W-1:0] len1;
        logic [PHASE_W-1:0] len2;
        rmode_e             mode;
    } cfg_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned BASE_LOG2 = 25,
    parameter int unsigned SCALE_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               clear_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);
    localparam int unsigned MAX_SHIFT = BASE_LOG2 + (1 << SCALE_W) - 1;
    localparam int unsigned CNT_W     = MAX_SHIFT + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        last_val = (CNT_W'(1) << (BASE_LOG2 + 32'(scale_i))) - CNT_W'(1);
        tick_o   = run_i && (cnt_q >= last_val);
        if (!run_i || clear_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && tick_i && (cnt_q >= limit_i);
        cnt_d    = cnt_q;
        if (!run_i || clear_i || expire_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse
    import wdt_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fire_i,
    input  rmode_e             mode_i,
    output logic [NUM_TGT-1:0] pulse_o
);
    logic [NUM_TGT-1:0] pulse_d, pulse_q;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        always_comb begin
            pulse_d[g] = fire_i && (mode_i == rmode_e'(g));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 25
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_we_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  irq_pre_o,
    output logic                  rst_chip_o,
    output logic                  rst_cpu_o,
    output logic                  rst_soft_o
);
    typedef struct packed {
        phase_e phase;
        cfg_t   cfg;
        logic   flag1;
        logic   flag2;
    } state_t;

    localparam cfg_t   CFG_RST   = '{scale: '0, len1: '0, len2: '0, mode: RM_CPU};
    localparam state_t STATE_RST = '{phase: PH_IDLE, cfg: CFG_RST, flag1: 1'b0, flag2: 1'b0};

    state_t st_d, st_q;

    logic               hit_kick, wr_stat, wr_ctrl, wr_en;
    logic               running, in_first, cnt_clear;
    logic               tick, ph_expire, fire;
    logic [PHASE_W-1:0] limit;
    logic [NUM_TGT-1:0] pulse;
    phase_e             phase_q;
    logic               flag2_q;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata_i;

    // Bus decode
    always_comb begin
        hit_kick  = bus_we_i && (bus_addr_i == OFS_KICK) && bus_wdata_i[KICK_BIT];
        wr_stat   = bus_we_i && (bus_addr_i == OFS_STAT);
        wr_ctrl   = bus_we_i && (bus_addr_i == OFS_CTRL);
        wr_en     = bus_wdata_i[CTL_EN_BIT];
        running   = (st_q.phase != PH_IDLE);
        in_first  = (st_q.phase == PH_FIRST);
        cnt_clear = in_first && (hit_kick || (wr_ctrl && !wr_en));
        limit     = (st_q.phase == PH_SECOND) ? st_q.cfg.len2 : st_q.cfg.len1;
    end

    wdt_prescaler #(
        .BASE_LOG2 (BASE_LOG2),
        .SCALE_W   (SCALE_W)
    ) u_presc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (running),
        .clear_i (cnt_clear),
        .scale_i (st_q.cfg.scale),
        .tick_o  (tick)
    );

    wdt_tick_counter #(
        .CNT_W (PHASE_W)
    ) u_ticks (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (running),
        .clear_i  (cnt_clear),
        .tick_i   (tick),
        .limit_i  (limit),
        .expire_o (ph_expire)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        fire = 1'b0;

        if (wr_ctrl) begin
            st_d.cfg.scale = bus_wdata_i[CTL_PS_LSB +: SCALE_W];
            st_d.cfg.len1  = bus_wdata_i[CTL_F1_LSB +: PHASE_W];
            st_d.cfg.len2  = bus_wdata_i[CTL_F2_LSB +: PHASE_W];
            st_d.cfg.mode  = rmode_e'(bus_wdata_i[CTL_MD_LSB +: MODE_W]);
        end

        if (wr_stat && bus_wdata_i[STAT_F1_BIT]) begin
            st_d.flag1 = 1'b0;
        end
        if (wr_stat && bus_wdata_i[STAT_F2_BIT]) begin
            st_d.flag2 = 1'b0;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (wr_ctrl && wr_en) begin
                    st_d.phase = PH_FIRST;
                end
            end
            PH_FIRST: begin
                if (wr_ctrl && !wr_en) begin
                    st_d.phase = PH_IDLE;
                end else if (!hit_kick && ph_expire) begin
                    st_d.phase = PH_SECOND;
                    st_d.flag1 = 1'b1;
                end
            end
            PH_SECOND: begin
                if (ph_expire) begin
                    st_d.phase = PH_IDLE;
                    st_d.flag2 = 1'b1;
                    fire       = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    wdt_reset_pulse u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fire_i  (fire),
        .mode_i  (st_q.cfg.mode),
        .pulse_o (pulse)
    );

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            OFS_CTRL: begin
                bus_rdata_o[CTL_EN_BIT]              = running;
                bus_rdata_o[CTL_PS_LSB +: SCALE_W]   = st_q.cfg.scale;
                bus_rdata_o[CTL_F1_LSB +: PHASE_W]   = st_q.cfg.len1;
                bus_rdata_o[CTL_F2_LSB +: PHASE_W]   = st_q.cfg.len2;
                bus_rdata_o[CTL_MD_LSB +: MODE_W]    = st_q.cfg.mode;
            end
            OFS_STAT: begin
                bus_rdata_o[STAT_F1_BIT] = st_q.flag1;
                bus_rdata_o[STAT_F2_BIT] = st_q.flag2;
            end
            default: begin
                bus_rdata_o = '0;
            end
        endcase
    end

    assign phase_q    = st_q.phase;
    assign flag2_q    = st_q.flag2;
    assign irq_pre_o  = st_q.flag1;
    assign rst_chip_o = pulse[RM_CHIP];
    assign rst_cpu_o  = pulse[RM_CPU];
    assign rst_soft_o = pulse[RM_SOFT];

endmodule

// File: rtl/wdt_two_phase_chk.sv
module wdt_two_phase_chk
    import wdt_pkg::*;
(
    input logic   clk_i,
    input logic   rst_ni,
    input logic   irq_pre_o,
    input logic   rst_chip_o,
    input logic   rst_cpu_o,
    input logic   rst_soft_o,
    input phase_e phase_i,
    input logic   flag2_i
);
    logic [NUM_TGT-1:0] rst_vec;
    assign rst_vec = {rst_soft_o, rst_cpu_o, rst_chip_o};

    // R4
    reset_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rst_vec));

    // R5
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rst_vec) |=> (rst_vec == '0));

    // R5
    pulse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rst_vec) |-> (phase_i == PH_IDLE));

    // R3
    pulse_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rst_vec) |-> flag2_i);

    // R3
    pulse_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rst_vec) |-> ($past(phase_i) == PH_SECOND));

    // R10
    second_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == PH_SECOND) |=> ((phase_i == PH_SECOND) || flag2_i));

    // R2
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_pre_o) |-> (phase_i == PH_SECOND));

endmodule

bind wdt_two_phase wdt_two_phase_chk u_wdt_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_pre_o  (irq_pre_o),
    .rst_chip_o (rst_chip_o),
    .rst_cpu_o  (rst_cpu_o),
    .rst_soft_o (rst_soft_o),
    .phase_i    (phase_q),
    .flag2_i    (flag2_q)
);

// File: tb/test_wdt_two_phase.sv
module test_wdt_two_phase;
    localparam int unsigned BASE     = 2;
    localparam int unsigned WD_LIMIT = 150000;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        we    = 1'b0;
    logic [3:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, r_chip, r_cpu, r_soft;

    int unsigned cyc = 0;
    int          checks = 0;
    int          fails  = 0;
    int          irq_rises = 0;
    int unsigned irq_rise_cyc = 0;
    int          rst_pulses = 0;
    int          rst_hi = 0;
    int unsigned rst_cyc = 0;
    int unsigned rst_which = 0;
    logic        irq_prev = 1'b0;
    logic        rst_prev = 1'b0;

    always #2 clk = ~clk;

    wdt_two_phase #(.BASE_LOG2(BASE)) i_wdt_two_phase (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_pre_o   (irq),
        .rst_chip_o  (r_chip),
        .rst_cpu_o   (r_cpu),
        .rst_soft_o  (r_soft)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !irq_prev) begin
                irq_rises    = irq_rises + 1;
                irq_rise_cyc = cyc;
            end
            irq_prev = irq;
            if (r_chip || r_cpu || r_soft) begin
                rst_hi = rst_hi + 1;
                if (!rst_prev) begin
                    rst_pulses = rst_pulses + 1;
                    rst_cyc    = cyc;
                    rst_which  = {29'd0, r_soft, r_cpu, r_chip};
                end
            end
            rst_prev = r_chip || r_cpu || r_soft;
        end
    end

    task automatic chk_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        step();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic run_to(int unsigned e);
        while (cyc < e) step();
    endtask

    function automatic logic [31:0] ctrl_word(bit en, int ps, int f1, int f2, int md);
        return {en, 2'(ps), 2'b00, 5'(f1), 2'b00, 5'(f2), 13'd0, 2'(md)};
    endfunction

    function automatic int unsigned tick_len(int ps);
        return 32'd1 << (BASE + ps);
    endfunction

    task automatic full_run(int ps, int f1, int f2, int md);
        logic [31:0] v;
        int unsigned k, e1, et;
        int i0, p0, h0;
        wr(4'h4, 32'hC000_0000);
        i0 = irq_rises; p0 = rst_pulses; h0 = rst_hi;
        wr(4'h8, ctrl_word(1'b1, ps, f1, f2, md));
        k  = cyc;
        e1 = k + tick_len(ps) * (f1 + 1);
        et = e1 + tick_len(ps) * (f2 + 1);
        run_to(et + 2 * tick_len(ps));
        chk_eq("R2 one interrupt", irq_rises - i0, 1);
        chk_eq("R2 interrupt edge", irq_rise_cyc, e1);
        if (md != 3) begin
            chk_eq("R3 reset edge", rst_cyc, et);
            chk_eq("R4 reset target", rst_which, 1 << md);
            chk_eq("R5 pulse width", rst_hi - h0, 1);
        end else begin
            chk_eq("R4 reserved mode no pulse", rst_pulses - p0, 0);
        end
        rd(4'h4, v);
        chk_eq("R3 status both flags", v, 32'hC000_0000);
        chk_eq("R6 irq follows flag", irq, 1);
        rd(4'h8, v);
        chk_eq("R5 enable cleared after reset", v[31], 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned k, p, d, k2;
        int i0, p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h8, v); chk_eq("R1 ctrl reset value", v, 32'h0000_0001);
        rd(4'h4, v); chk_eq("R1 status reset value", v, 0);
        rd(4'h0, v); chk_eq("R1 kick reg reads zero", v, 0);
        chk_eq("R1 outputs low", {irq, r_chip, r_cpu, r_soft}, 0);

        // R7 field readback
        wr(4'h8, 32'h7FFF_FFFF);
        rd(4'h8, v); chk_eq("R7 ctrl readback", v, 32'h67CF_8003);
        rd(4'h0, v); chk_eq("R7 kick reg reads zero", v, 0);
        wr(4'h8, 32'h0);
        rd(4'h8, v); chk_eq("R7 ctrl cleared", v, 0);

        // Directed full runs, every mode
        full_run(0, 0, 0, 0);
        full_run(3, 31, 31, 1);
        full_run(2, 5, 9, 3);
        full_run(1, 17, 2, 2);

        // R8: kick in phase one restarts it
        wr(4'h4, 32'hC000_0000);
        i0 = irq_rises;
        wr(4'h8, ctrl_word(1'b1, 1, 3, 1, 2));
        k = cyc;
        run_to(k + 20);
        wr(4'h0, 32'h8000_0000);
        p = cyc;
        run_to(p + 56);
        chk_eq("R8 one interrupt after kick", irq_rises - i0, 1);
        chk_eq("R8 interrupt delayed by kick", irq_rise_cyc, p + 32);
        chk_eq("R8 reset delayed by kick", rst_cyc, p + 48);

        // R8: kick on the expiry edge wins
        wr(4'h4, 32'hC000_0000);
        wr(4'h8, ctrl_word(1'b1, 0, 1, 0, 1));
        k = cyc;
        run_to(k + 7);
        wr(4'h0, 32'h8000_0000);
        chk_eq("R8 kick at expiry suppresses irq", irq, 0);
        run_to(k + 24);
        chk_eq("R8 interrupt after coincident kick", irq_rise_cyc, k + 16);
        chk_eq("R8 reset after coincident kick", rst_cyc, k + 20);

        // R9: kick in phase two ignored
        wr(4'h4, 32'hC000_0000);
        wr(4'h8, ctrl_word(1'b1, 0, 0, 7, 0));
        k = cyc;
        run_to(k + 10);
        wr(4'h0, 32'h8000_0000);
        run_to(k + 40);
        chk_eq("R9 interrupt edge", irq_rise_cyc, k + 4);
        chk_eq("R9 reset on schedule", rst_cyc, k + 36);
        chk_eq("R9 chip reset target", rst_which, 1);

        // R6: clear on the set edge loses; R10: disable in phase two ignored
        wr(4'h4, 32'hC000_0000);
        wr(4'h8, ctrl_word(1'b1, 0, 2, 5, 2));
        k = cyc;
        run_to(k + 11);
        wr(4'h4, 32'h8000_0000);
        rd(4'h4, v); chk_eq("R6 set wins over clear", v[31], 1);
        chk_eq("R6 irq high after coincident clear", irq, 1);
        wr(4'h4, 32'h8000_0000);
        rd(4'h4, v); chk_eq("R6 clear takes effect", v, 0);
        chk_eq("R6 irq low after clear", irq, 0);
        wr(4'h8, ctrl_word(1'b0, 0, 2, 5, 2));
        rd(4'h8, v); chk_eq("R10 enable still reads one", v[31], 1);
        run_to(k + 40);
        chk_eq("R10 reset on schedule", rst_cyc, k + 36);
        chk_eq("R10 soft reset target", rst_which, 4);

        // R11: disable in phase one
        wr(4'h4, 32'hC000_0000);
        i0 = irq_rises; p0 = rst_pulses;
        wr(4'h8, ctrl_word(1'b1, 0, 3, 0, 1));
        k = cyc;
        run_to(k + 10);
        wr(4'h8, ctrl_word(1'b0, 0, 3, 0, 1));
        d = cyc;
        run_to(d + 40);
        chk_eq("R11 no interrupt when stopped", irq_rises - i0, 0);
        chk_eq("R11 no reset when stopped", rst_pulses - p0, 0);
        rd(4'h8, v); chk_eq("R11 enable reads zero", v[31], 0);
        wr(4'h8, ctrl_word(1'b1, 0, 3, 0, 1));
        k2 = cyc;
        run_to(k2 + 24);
        chk_eq("R11 restart from zero irq", irq_rise_cyc, k2 + 16);
        chk_eq("R11 restart from zero reset", rst_cyc, k2 + 20);

        // Random runs with a fixed seed
        v = $urandom(32'hB0A7_5EED);
        for (int n = 0; n < 8; n++) begin
            full_run(int'($urandom % 4), int'($urandom % 32),
                     int'($urandom % 32), int'($urandom % 4));
        end

        summary();
        $finish;
    end

endmodule